// File: doc/BRIEF.md
# Poison-Tagged Register File for Deferred Speculative Faults

This block is a register file in which each register carries a one-bit poison tag next to its data. A speculative instruction that hits a fatal-class fault does not trap. Its destination is written with poison instead. The fault stays dormant until one of two things happens: a non-speculative instruction consumes that register, or an explicit check operation tests it.

A non-speculative consumer that reads poison drives a fatal-exception output, and the program is then terminated outside this block. A check operation placed where the speculated instruction originally sat asks for recovery when the tag it tests is set.

Speculative consumers of poison pass the tag on to their own destination. This lets a deferred fault travel through a chain of speculative code without being raised.

The block has one write port, a parameterized number of operand read ports that share a consumer speculative flag, and one check port. Reads are combinational and bypass a write to the same register in the same cycle. Classifying faults and running the recovery handler are left to the surrounding pipeline.

Top module: `ptag_regfile`

## Requirements
- R1: Reset (synchronous, active high) clears the data and poison tag of every register; afterwards any read returns data 0 and tag 0.
- R2: A write whose fault code is none (2'b00) or resumable (2'b01), and whose source-poison flag is low, stores its data and clears the destination tag.
- R3: A speculative write whose fault code has bit 1 set (fatal, 2'b10 or 2'b11) sets the destination tag and stores data 0.
- R4: A speculative write whose source-poison flag is high sets the destination tag and stores data 0, whatever its fault code.
- R5: A non-speculative write always stores its data and clears the destination tag, whatever its fault code or source-poison flag.
- R6: Register 0 always reads data 0 and tag 0; writes to it have no effect.
- R7: Each read port returns the stored data and tag of its index in the same cycle, with no clock edge in between.
- R8: When a write targets the register that a read or check port names in the same cycle, that port returns the value and tag being written.
- R9: fat_o is high exactly when the read enable is high, the consumer speculative flag is low, and at least one read port returns tag 1.
- R10: rcv_o is high exactly when the check enable is high and the checked register's tag, with bypass applied, is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | IW | Destination register index |
| wr_data | input | DW | Write data |
| wr_spec | input | 1 | Producing instruction is speculative |
| wr_fault | input | 2 | Fault code: 00 none, 01 resumable, 1x fatal |
| wr_srcp | input | 1 | Producing instruction read a poisoned source |
| rd_en | input | 1 | Operand read is valid (consumer present) |
| rd_spec | input | 1 | Consumer is speculative |
| rd_idx | input | NRP*IW | Read indices, port p at bits p*IW |
| rd_data | output | NRP*DW | Read data, port p at bits p*DW |
| rd_tag | output | NRP | Read poison tags, one per port |
| fat_o | output | 1 | Non-speculative use of poison |
| chk_en | input | 1 | Check operation valid |
| chk_idx | input | IW | Register tested by the check |
| rcv_o | output | 1 | Recovery request |

## Verification
Read data, read tags, fat_o and rcv_o are combinational, so they are due in the same cycle as the inputs that cause them. The bench drives inputs on the falling edge and samples 2 ns later, before the next rising edge. A write becomes part of the stored state at the next rising edge. Each write is therefore checked twice: once through the bypass in its own cycle, and once from storage in the following cycle with the write enable low. Fatal and recovery outputs are sampled in those same two windows, once with a non-speculative consumer and once with a speculative one.

// File: rtl/ptag_pkg.sv
package ptag_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_RESUME = 2'b01,
        FLT_FATAL  = 2'b10,
        FLT_FATAL2 = 2'b11
    } fault_e;

    typedef struct packed {
        logic   en;
        logic   spec;
        fault_e fault;
        logic   srcp;
    } wr_ctl_t;

    // Poison is produced only by speculative work that faulted fatally
    // or consumed an already-poisoned operand.
    function automatic logic poison_next(input wr_ctl_t c);
        return c.spec & (c.fault[1] | c.srcp);
    endfunction

endpackage

// File: rtl/ptag_store.sv
module ptag_store
    import ptag_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int DW    = 16,
    parameter int IW    = $clog2(NREGS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [IW-1:0]         widx,
    input  logic [DW-1:0]         wdata,
    input  logic                  wtag,
    output logic [NREGS*DW-1:0]   mem_data,
    output logic [NREGS-1:0]      mem_tag
);
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign mem_data[DW-1:0] = '0;
            assign mem_tag[0]       = 1'b0;
        end else begin : g_live
            logic [DW-1:0] d_q;
            logic          t_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    d_q <= '0;
                    t_q <= 1'b0;
                end else if (we && widx == IW'(g)) begin
                    d_q <= wdata;
                    t_q <= wtag;
                end
            end
            assign mem_data[g*DW +: DW] = d_q;
            assign mem_tag[g]           = t_q;
        end
    end
endmodule

// File: rtl/ptag_rdport.sv
module ptag_rdport
    import ptag_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int DW    = 16,
    parameter int IW    = $clog2(NREGS)
) (
    input  logic [IW-1:0]         idx,
    input  logic [NREGS*DW-1:0]   mem_data,
    input  logic [NREGS-1:0]      mem_tag,
    input  logic                  byp_en,
    input  logic [IW-1:0]         byp_idx,
    input  logic [DW-1:0]         byp_data,
    input  logic                  byp_tag,
    output logic [DW-1:0]         data,
    output logic                  tag
);
    always_comb begin
        if (idx == '0) begin
            data = '0;
            tag  = 1'b0;
        end else if (byp_en && byp_idx == idx) begin
            data = byp_data;
            tag  = byp_tag;
        end else begin
            data = mem_data[idx*DW +: DW];
            tag  = mem_tag[idx];
        end
    end
endmodule

// File: rtl/ptag_regfile.sv
module ptag_regfile
    import ptag_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int DW    = 16,
    parameter int NRP   = 2,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [DW-1:0]        wr_data,
    input  logic                 wr_spec,
    input  logic [1:0]           wr_fault,
    input  logic                 wr_srcp,
    input  logic                 rd_en,
    input  logic                 rd_spec,
    input  logic [NRP*IW-1:0]    rd_idx,
    output logic [NRP*DW-1:0]    rd_data,
    output logic [NRP-1:0]       rd_tag,
    output logic                 fat_o,
    input  logic                 chk_en,
    input  logic [IW-1:0]        chk_idx,
    output logic                 rcv_o
);
    wr_ctl_t              wc;
    logic                 w_live;
    logic                 w_tag;
    logic [DW-1:0]        w_data;
    logic [NREGS*DW-1:0]  mem_data;
    logic [NREGS-1:0]     mem_tag;
    logic [DW-1:0]        chk_data_unused;
    logic                 chk_tag;

    always_comb begin
        wc.en    = wr_en;
        wc.spec  = wr_spec;
        wc.fault = fault_e'(wr_fault);
        wc.srcp  = wr_srcp;
        w_live   = wc.en && (wr_idx != '0);
        w_tag    = poison_next(wc);
        w_data   = w_tag ? '0 : wr_data;
    end

    ptag_store #(.NREGS(NREGS), .DW(DW), .IW(IW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (w_live),
        .widx     (wr_idx),
        .wdata    (w_data),
        .wtag     (w_tag),
        .mem_data (mem_data),
        .mem_tag  (mem_tag)
    );

    for (genvar p = 0; p < NRP; p++) begin : g_rd
        ptag_rdport #(.NREGS(NREGS), .DW(DW), .IW(IW)) u_port (
            .idx      (rd_idx[p*IW +: IW]),
            .mem_data (mem_data),
            .mem_tag  (mem_tag),
            .byp_en   (w_live),
            .byp_idx  (wr_idx),
            .byp_data (w_data),
            .byp_tag  (w_tag),
            .data     (rd_data[p*DW +: DW]),
            .tag      (rd_tag[p])
        );
    end

    ptag_rdport #(.NREGS(NREGS), .DW(DW), .IW(IW)) u_chk_port (
        .idx      (chk_idx),
        .mem_data (mem_data),
        .mem_tag  (mem_tag),
        .byp_en   (w_live),
        .byp_idx  (wr_idx),
        .byp_data (w_data),
        .byp_tag  (w_tag),
        .data     (chk_data_unused),
        .tag      (chk_tag)
    );

    assign fat_o = rd_en && !rd_spec && (|rd_tag);
    assign rcv_o = chk_en && chk_tag;
endmodule

// File: rtl/ptag_regfile_chk.sv
module ptag_regfile_chk #(
    parameter int NREGS = 8,
    parameter int DW    = 16,
    parameter int NRP   = 2,
    localparam int IW   = $clog2(NREGS)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [IW-1:0]     wr_idx,
    input logic [DW-1:0]     wr_data,
    input logic              wr_spec,
    input logic [1:0]        wr_fault,
    input logic              wr_srcp,
    input logic              rd_en,
    input logic              rd_spec,
    input logic [NRP*IW-1:0] rd_idx,
    input logic [NRP*DW-1:0] rd_data,
    input logic [NRP-1:0]    rd_tag,
    input logic              fat_o,
    input logic              chk_en,
    input logic [IW-1:0]     chk_idx,
    input logic              rcv_o
);
    a_r9_fatal_only_nonspec: assert property (@(posedge clk) disable iff (rst)
        fat_o |-> (rd_en && !rd_spec && (rd_tag != '0)));

    a_r10_recover_needs_check: assert property (@(posedge clk) disable iff (rst)
        rcv_o |-> chk_en);

    a_r6_zero_reads_clean: assert property (@(posedge clk) disable iff (rst)
        (rd_idx[IW-1:0] == '0) |-> (rd_data[DW-1:0] == '0 && !rd_tag[0]));

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !wr_en) |-> (rd_tag == '0 && !rcv_o));

    a_r3_poison_held: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en && wr_idx != '0 && wr_spec && wr_fault[1])
         && rd_idx[IW-1:0] == $past(wr_idx) && !wr_en)
        |-> (rd_tag[0] && rd_data[DW-1:0] == '0));

    a_r5_nonspec_clean: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en && wr_idx != '0 && !wr_spec)
         && rd_idx[IW-1:0] == $past(wr_idx) && !wr_en)
        |-> (!rd_tag[0] && rd_data[DW-1:0] == $past(wr_data)));
endmodule

bind ptag_regfile ptag_regfile_chk #(.NREGS(NREGS), .DW(DW), .NRP(NRP)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_spec(wr_spec), .wr_fault(wr_fault), .wr_srcp(wr_srcp), .rd_en(rd_en),
    .rd_spec(rd_spec), .rd_idx(rd_idx), .rd_data(rd_data), .rd_tag(rd_tag),
    .fat_o(fat_o), .chk_en(chk_en), .chk_idx(chk_idx), .rcv_o(rcv_o)
);

// File: tb/sim_ptag_regfile.sv
module sim_ptag_regfile;
    localparam int NREGS = 8;
    localparam int DW    = 16;
    localparam int NRP   = 2;
    localparam int IW    = $clog2(NREGS);

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en, wr_spec, wr_srcp;
    logic [IW-1:0]     wr_idx;
    logic [DW-1:0]     wr_data;
    logic [1:0]        wr_fault;
    logic              rd_en, rd_spec;
    logic [NRP*IW-1:0] rd_idx;
    logic [NRP*DW-1:0] rd_data;
    logic [NRP-1:0]    rd_tag;
    logic              fat_o;
    logic              chk_en;
    logic [IW-1:0]     chk_idx;
    logic              rcv_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ptag_regfile #(.NREGS(NREGS), .DW(DW), .NRP(NRP)) u0 (.*);

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_spec = 0; wr_srcp = 0; wr_idx = '0; wr_data = '0; wr_fault = 2'b00;
        rd_en = 0; rd_spec = 0; rd_idx = '0; chk_en = 0; chk_idx = '0;
    endtask

    initial begin
        #150000;
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: every register clean after reset
        for (int r = 0; r < NREGS; r++) begin
            rd_idx = {IW'(r), IW'(r)};
            chk_en = 1; chk_idx = IW'(r);
            rd_en = 1;
            #1;
            chk("R1 data", rd_data[DW-1:0], '0);
            chk("R1 tag", {15'd0, rd_tag[0]}, 0);
            chk("R1 fatal", {15'd0, fat_o}, 0);
        end
        // Sweep every register and every write-control combination
        for (int r = 1; r < NREGS; r++) begin
            for (int c = 0; c < 16; c++) begin
                logic sp, srcp, etag;
                logic [1:0] f;
                logic [DW-1:0] d, edat;
                sp = c[0]; srcp = c[1]; f = c[3:2];
                d = DW'(r * 256 + c * 7 + 1);
                etag = sp && (f[1] || srcp);          // R3/R4 poison, else R2/R5
                edat = etag ? '0 : d;
                @(negedge clk);
                idle();
                wr_en = 1; wr_idx = IW'(r); wr_data = d; wr_spec = sp;
                wr_fault = f; wr_srcp = srcp;
                rd_idx = {IW'(0), IW'(r)};
                chk_en = 1; chk_idx = IW'(r);
                rd_en = 1; rd_spec = 1;
                #2;
                chk("R8 bypass data", rd_data[DW-1:0], edat);
                chk("R8 bypass tag", {15'd0, rd_tag[0]}, {15'd0, etag});
                chk("R10 recover bypass", {15'd0, rcv_o}, {15'd0, etag});
                chk("R9 spec consumer no fatal", {15'd0, fat_o}, 0);
                @(negedge clk);
                idle();
                rd_idx = {IW'(r), IW'(0)};
                rd_en = 1; rd_spec = 0;
                chk_en = 1; chk_idx = IW'(r);
                #2;
                if (etag) chk(sp && f[1] ? "R3 stored data" : "R4 stored data", rd_data[2*DW-1:DW], edat);
                else if (!sp) chk("R5 stored data", rd_data[2*DW-1:DW], edat);
                else chk("R2 stored data", rd_data[2*DW-1:DW], edat);
                chk("R7 stored tag", {15'd0, rd_tag[1]}, {15'd0, etag});
                chk("R6 port0 reg0", rd_data[DW-1:0], '0);
                chk("R9 fatal nonspec", {15'd0, fat_o}, {15'd0, etag});
                chk("R10 recover stored", {15'd0, rcv_o}, {15'd0, etag});
                rd_spec = 1; chk_en = 0;
                #1;
                chk("R9 fatal spec", {15'd0, fat_o}, 0);
                chk("R10 no check no recover", {15'd0, rcv_o}, 0);
            end
        end
        // R6: register 0 ignores a poisoning write
        @(negedge clk);
        idle();
        wr_en = 1; wr_idx = '0; wr_data = 16'hBEEF; wr_spec = 1; wr_fault = 2'b10;
        rd_en = 1; chk_en = 1; chk_idx = '0;
        #2;
        chk("R6 reg0 bypass data", rd_data[DW-1:0], '0);
        chk("R6 reg0 recover", {15'd0, rcv_o}, 0);
        @(negedge clk);
        idle();
        rd_en = 1; chk_en = 1;
        #2;
        chk("R6 reg0 tag", {15'd0, rd_tag[0]}, 0);
        chk("R6 reg0 fatal", {15'd0, fat_o}, 0);
        // R9: poison on second port only, first port clean
        @(negedge clk);
        idle();
        wr_en = 1; wr_idx = 3'd1; wr_spec = 1; wr_fault = 2'b11;
        @(negedge clk);
        idle();
        wr_en = 1; wr_idx = 3'd2; wr_data = 16'h1234; wr_spec = 1; wr_fault = 2'b01;
        @(negedge clk);
        idle();
        rd_idx = {IW'(1), IW'(2)};
        rd_en = 1;
        #2;
        chk("R9 fatal via port1", {15'd0, fat_o}, 1);
        chk("R2 resumable keeps data", rd_data[DW-1:0], 16'h1234);
        rd_en = 0;
        #1;
        chk("R9 no read no fatal", {15'd0, fat_o}, 0);
        // R1: reset again clears poison
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0; idle();
        rd_idx = {IW'(1), IW'(2)}; rd_en = 1;
        #2;
        chk("R1 reset clears tag", {15'd0, rd_tag[1]}, 0);
        chk("R1 reset clears data", rd_data[DW-1:0], '0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule